// File: doc/BRIEF.md
# Doorbell-Triggered DMA Read Requester

This block watches a 64-bit inbound packet-layer stream. Each beat carries start, end and valid flags, plus a flag that marks hits on the first base address region. Software rings the doorbell by posting a 3-DW memory write into that region. The register offset of the write is read as a command word. The 64-bit data value of the write is the host buffer address.

When the command code is SEND, the block builds a 3-DW memory read request. The request length, tag and address come from the fields of the command word and from the written data. The block emits the request as two beats on a 64-bit outbound stream, which is stalled by a ready input. The other command codes (status, receive, management) are decoded and discarded. One request may wait behind the one being sent. A further one may sit in a one-deep holding slot. Anything beyond that is dropped.

Top module: `dbell_rdreq`

## Requirements
- R1: After a synchronous active-high reset, out_vld, out_sop, out_eop, out_half and out_data are all zero, and no request is pending.
- R2: An inbound write is recognised only as a start beat with header bits 62:61 = 10 and bits 60:56 = 00000. It is followed by a beat whose upper half (bits 63:32) is the command word, then an end beat whose upper half is the low 32 bits of the host address.
- R3: In the command word, bits 4:3 are the command code, bits 8:5 the buffer number and bits 18:10 the length in quadwords. Only code 01 (SEND) produces a request. Codes 00, 10 and 11 produce no outbound traffic.
- R4: The first outbound beat has out_sop=1, out_eop=0 and out_half=0. Bits 63:42 are zero. Bits 41:32 hold the quadword count shifted left by one. Bits 31:16 are local_id. Bits 15:8 are the buffer number zero-extended. Bits 7:0 are 0xFF.
- R5: The second outbound beat has out_eop=1 and out_half=1. Bits 63:35 are host address bits 31:3, and bits 34:0 are zero, so the host address is forced to quadword alignment.
- R6: The first outbound beat becomes valid two clock edges after the edge that samples the inbound end beat. Nothing is valid at the two sampling points before that.
- R7: While out_vld is high and out_rdy is low, every outbound signal holds its value.
- R8: Once the second beat is accepted, the next cycle shows all outbound signals zero. Whenever out_vld is low, out_data and the flags are zero.
- R9: Beats with in_vld low, or with in_hit low, are ignored even when they fall in the middle of a write. Write packets outside the region, and packets whose header is not a 3-DW write (for example a read), do not produce a request.
- R10: With the outbound stream stalled, a request that arrives while another is waiting goes into a one-deep holding slot. Further SEND commands are dropped until that slot frees up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 64 | Inbound beat payload |
| in_sop | input | 1 | Inbound start-of-packet flag |
| in_eop | input | 1 | Inbound end-of-packet flag |
| in_vld | input | 1 | Inbound beat valid |
| in_hit | input | 1 | Inbound beat targets the doorbell region |
| out_rdy | input | 1 | Outbound sink accepts the current beat |
| local_id | input | 16 | Requester ID placed in emitted headers |
| out_data | output | 64 | Outbound beat payload |
| out_sop | output | 1 | Outbound start-of-packet flag |
| out_eop | output | 1 | Outbound end-of-packet flag |
| out_half | output | 1 | Only the upper half of the beat is meaningful |
| out_vld | output | 1 | Outbound beat valid |

## Verification
A SEND header is due at the third sampling point after the edge that takes the inbound end beat. The address beat is due one accepted cycle later, and the bus is back to zero one cycle after that. A directed check counts those exact falling-edge sampling points. A reference model works out its state at each rising edge from the inputs held there. The bench then compares every output against that model on the following falling edge. Inputs change only shortly after a rising edge, so both model and design see the same values. Request counts for the queueing, dropping and ignored-packet cases are taken only after the output has drained.

// File: rtl/dbrq_pkg.sv
package dbrq_pkg;
    localparam int BEAT_W  = 64;
    localparam int HALF_W  = BEAT_W / 2;
    localparam int QW_W    = 9;
    localparam int BUF_W   = 4;
    localparam int RID_W   = 16;
    localparam int TAG_W   = 8;
    localparam int SLOTS   = 2;

    localparam logic [1:0] FMT_WR3 = 2'b10;
    localparam logic [1:0] FMT_RD3 = 2'b00;
    localparam logic [4:0] TYP_MEM = 5'b00000;
    localparam logic [7:0] BE_ALL  = 8'hFF;

    typedef enum logic [1:0] {
        OP_STAT = 2'b00,
        OP_SEND = 2'b01,
        OP_RECV = 2'b10,
        OP_MGMT = 2'b11
    } op_e;

    typedef struct packed {
        logic [QW_W-1:0]   qw;
        logic [BUF_W-1:0]  bufn;
        logic [HALF_W-1:0] haddr;
    } rdreq_t;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_HDR  = 2'd1,
        TX_ADR  = 2'd2
    } txst_e;

    function automatic logic [BEAT_W-1:0] hdr_beat(rdreq_t r, logic [RID_W-1:0] rid);
        return {1'b0, FMT_RD3, TYP_MEM, 8'h00, 6'b0, r.qw, 1'b0, rid,
                {(TAG_W-BUF_W){1'b0}}, r.bufn, BE_ALL};
    endfunction

    function automatic logic [BEAT_W-1:0] adr_beat(rdreq_t r);
        return {r.haddr[HALF_W-1:3], 3'b000, {HALF_W{1'b0}}};
    endfunction
endpackage

// File: rtl/dbrq_rx_decode.sv
module dbrq_rx_decode
    import dbrq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BEAT_W-1:0] in_data,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic              in_vld,
    input  logic              in_hit,
    output logic              req_v,
    output rdreq_t            req
);
    logic [1:0]        beat_q;
    logic              is_wr_q;
    logic [HALF_W-1:0] cmdw_q;
    logic              take;
    op_e               op;

    assign take = in_vld && in_hit;
    assign op   = op_e'(cmdw_q[4:3]);

    wire unused_rx = ^{in_data[HALF_W-1:0], in_data[55:0], in_data[63], cmdw_q[31:19],
                      cmdw_q[9], cmdw_q[2:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q  <= 2'd0;
            is_wr_q <= 1'b0;
            cmdw_q  <= '0;
            req_v   <= 1'b0;
            req     <= '0;
        end else begin
            req_v <= 1'b0;
            if (take) begin
                if (in_sop) begin
                    beat_q  <= 2'd1;
                    is_wr_q <= (in_data[62:61] == FMT_WR3) && (in_data[60:56] == TYP_MEM);
                end else if (beat_q == 2'd1) begin
                    cmdw_q <= in_data[BEAT_W-1:HALF_W];
                    beat_q <= in_eop ? 2'd0 : 2'd2;
                end else if (beat_q == 2'd2 && in_eop) begin
                    beat_q <= 2'd0;
                    if (is_wr_q && op == OP_SEND) begin
                        req_v     <= 1'b1;
                        req.qw    <= cmdw_q[18:10];
                        req.bufn  <= cmdw_q[8:5];
                        req.haddr <= in_data[BEAT_W-1:HALF_W];
                    end
                end else begin
                    beat_q <= 2'd0;
                end
            end
        end
    end
endmodule

// File: rtl/dbrq_req_queue.sv
module dbrq_req_queue
    import dbrq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   push,
    input  rdreq_t push_req,
    input  logic   pop,
    output logic   head_v,
    output rdreq_t head
);
    logic   v_q [SLOTS];
    rdreq_t e_q [SLOTS];
    logic   v_d [SLOTS];
    rdreq_t e_d [SLOTS];
    logic   placed;

    always_comb begin
        for (int i = 0; i < SLOTS; i++) begin
            if (pop) begin
                v_d[i] = (i + 1 < SLOTS) ? v_q[(i + 1) % SLOTS] : 1'b0;
                e_d[i] = (i + 1 < SLOTS) ? e_q[(i + 1) % SLOTS] : e_q[i];
            end else begin
                v_d[i] = v_q[i];
                e_d[i] = e_q[i];
            end
        end
        placed = 1'b0;
        for (int i = 0; i < SLOTS; i++) begin
            if (push && !placed && !v_d[i]) begin
                v_d[i] = 1'b1;
                e_d[i] = push_req;
                placed = 1'b1;
            end
        end
    end

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                v_q[g] <= 1'b0;
                e_q[g] <= '0;
            end else begin
                v_q[g] <= v_d[g];
                e_q[g] <= e_d[g];
            end
        end
    end

    assign head_v = v_q[0];
    assign head   = e_q[0];
endmodule

// File: rtl/dbrq_tx_framer.sv
module dbrq_tx_framer
    import dbrq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pend_v,
    input  rdreq_t            pend,
    input  logic [RID_W-1:0]  rid,
    input  logic              rdy,
    output logic              take,
    output logic [BEAT_W-1:0] o_data,
    output logic              o_sop,
    output logic              o_eop,
    output logic              o_half,
    output logic              o_vld
);
    txst_e  st_q;
    rdreq_t cur_q;

    assign take = (st_q == TX_IDLE) && pend_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= TX_IDLE;
            cur_q  <= '0;
            o_data <= '0;
            o_sop  <= 1'b0;
            o_eop  <= 1'b0;
            o_half <= 1'b0;
            o_vld  <= 1'b0;
        end else begin
            unique case (st_q)
                TX_IDLE: if (pend_v) begin
                    cur_q  <= pend;
                    o_data <= hdr_beat(pend, rid);
                    o_sop  <= 1'b1;
                    o_vld  <= 1'b1;
                    st_q   <= TX_HDR;
                end
                TX_HDR: if (rdy) begin
                    o_data <= adr_beat(cur_q);
                    o_sop  <= 1'b0;
                    o_eop  <= 1'b1;
                    o_half <= 1'b1;
                    st_q   <= TX_ADR;
                end
                TX_ADR: if (rdy) begin
                    o_data <= '0;
                    o_eop  <= 1'b0;
                    o_half <= 1'b0;
                    o_vld  <= 1'b0;
                    st_q   <= TX_IDLE;
                end
                default: st_q <= TX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dbell_rdreq.sv
module dbell_rdreq
    import dbrq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BEAT_W-1:0] in_data,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic              in_vld,
    input  logic              in_hit,
    input  logic              out_rdy,
    input  logic [RID_W-1:0]  local_id,
    output logic [BEAT_W-1:0] out_data,
    output logic              out_sop,
    output logic              out_eop,
    output logic              out_half,
    output logic              out_vld
);
    logic   dec_v;
    rdreq_t dec_r;
    logic   head_v;
    rdreq_t head_r;
    logic   pop;

    dbrq_rx_decode u_rx (
        .clk(clk), .rst(rst), .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop),
        .in_vld(in_vld), .in_hit(in_hit), .req_v(dec_v), .req(dec_r)
    );

    dbrq_req_queue u_q (
        .clk(clk), .rst(rst), .push(dec_v), .push_req(dec_r), .pop(pop),
        .head_v(head_v), .head(head_r)
    );

    dbrq_tx_framer u_tx (
        .clk(clk), .rst(rst), .pend_v(head_v), .pend(head_r), .rid(local_id),
        .rdy(out_rdy), .take(pop), .o_data(out_data), .o_sop(out_sop),
        .o_eop(out_eop), .o_half(out_half), .o_vld(out_vld)
    );
endmodule

// File: rtl/dbrq_checker.sv
module dbrq_checker (
    input logic        clk,
    input logic        rst,
    input logic        out_rdy,
    input logic [63:0] out_data,
    input logic        out_sop,
    input logic        out_eop,
    input logic        out_half,
    input logic        out_vld
);
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !out_vld |-> (out_data == 64'h0 && !out_sop && !out_eop && !out_half)); // R8

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_vld && !out_rdy) |=> (out_vld && $stable(out_data) && $stable(out_sop)
                                   && $stable(out_eop) && $stable(out_half))); // R7

    AST_HDR_FIELDS: assert property (@(posedge clk) disable iff (rst)
        (out_vld && out_sop) |-> (out_data[7:0] == 8'hFF && out_data[63:42] == 22'h0
                                  && !out_data[32] && !out_eop && !out_half)); // R4

    AST_HDR_TO_ADR: assert property (@(posedge clk) disable iff (rst)
        (out_vld && out_sop && out_rdy) |=> (out_vld && out_eop && !out_sop)); // R5

    AST_ADR_FIELDS: assert property (@(posedge clk) disable iff (rst)
        (out_vld && out_eop) |-> (out_half && out_data[34:0] == 35'h0)); // R5

    AST_ADR_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        (out_vld && out_eop && out_rdy) |=> !out_vld); // R8
endmodule

bind dbell_rdreq dbrq_checker u_chk (
    .clk(clk), .rst(rst), .out_rdy(out_rdy), .out_data(out_data), .out_sop(out_sop),
    .out_eop(out_eop), .out_half(out_half), .out_vld(out_vld)
);

// File: tb/tb_dbell_rdreq.sv
`timescale 1ns/1ps
module tb_dbell_rdreq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] in_data = '0;
    logic        in_sop = 1'b0, in_eop = 1'b0, in_vld = 1'b0, in_hit = 1'b0;
    logic        out_rdy = 1'b0;
    logic [15:0] local_id = 16'hA5C3;
    logic [63:0] out_data;
    logic        out_sop, out_eop, out_half, out_vld;

    dbell_rdreq dut (
        .clk(clk), .rst(rst), .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop),
        .in_vld(in_vld), .in_hit(in_hit), .out_rdy(out_rdy), .local_id(local_id),
        .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop),
        .out_half(out_half), .out_vld(out_vld)
    );

    always #5 clk = ~clk;

    int checks = 0, errors = 0, cyc = 0, n_hs = 0;
    bit started = 0, done = 0;

    task automatic chk(input string tag, input bit ok, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    typedef struct { int qw; int bn; logic [31:0] a; } mreq_t;
    mreq_t q[$];
    mreq_t m_pd, m_cur;
    bit    m_pd_v = 0, m_ov = 0, m_wr = 0;
    int    m_ob = 0, m_beat = 0;
    logic [31:0] m_cmd = '0;

    always @(posedge clk) begin
        cyc++;
        started = 1;
        if (rst) begin
            q.delete(); m_pd_v = 0; m_ov = 0; m_ob = 0; m_beat = 0; m_wr = 0;
        end else begin
            if (m_ov) begin
                if (out_rdy) begin
                    if (m_ob == 0) m_ob = 1; else m_ov = 0;
                end
            end else if (q.size() > 0) begin
                m_cur = q.pop_front(); m_ov = 1; m_ob = 0;
            end
            if (m_pd_v && q.size() < 2) q.push_back(m_pd);
            m_pd_v = 0;
            if (in_vld && in_hit) begin
                if (in_sop) begin
                    m_beat = 1;
                    m_wr = (in_data[63:56] == 8'h40) || (in_data[63:56] == 8'hC0);
                end else if (m_beat == 1) begin
                    m_cmd = in_data[63:32];
                    m_beat = in_eop ? 0 : 2;
                end else if (m_beat == 2 && in_eop) begin
                    m_beat = 0;
                    if (m_wr && ((m_cmd >> 3) & 3) == 1) begin
                        m_pd_v = 1;
                        m_pd.qw = (m_cmd >> 10) & 511;
                        m_pd.bn = (m_cmd >> 5) & 15;
                        m_pd.a  = in_data[63:32];
                    end
                end else m_beat = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (started && !done) begin
            logic [63:0] ed;
            if (out_vld && out_sop && out_rdy) n_hs++;
            if (!m_ov) begin
                chk("R8 idle vld", out_vld == 0, out_vld, 0);
                chk("R8 idle bus", {out_data, out_sop, out_eop, out_half} == '0, out_data, 0);
            end else if (m_ob == 0) begin
                ed = (64'(m_cur.qw) * 2 << 32) | (64'(local_id) << 16) | (64'(m_cur.bn) << 8) | 64'hFF;
                chk("R4 hdr data", out_data == ed, out_data, ed);
                chk("R4 hdr flags", {out_vld, out_sop, out_eop, out_half} == 4'b1100,
                    {out_vld, out_sop, out_eop, out_half}, 4'b1100);
            end else begin
                ed = 64'(m_cur.a & 32'hFFFF_FFF8) << 32;
                chk("R5 adr data", out_data == ed, out_data, ed);
                chk("R5 adr flags", {out_vld, out_sop, out_eop, out_half} == 4'b1011,
                    {out_vld, out_sop, out_eop, out_half}, 4'b1011);
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic tick(); @(posedge clk); #2; endtask

    task automatic beat(input logic [63:0] d, input bit s, input bit e, input bit v, input bit h);
        in_data = d; in_sop = s; in_eop = e; in_vld = v; in_hit = h;
        tick();
    endtask

    task automatic quiet(input int n);
        in_data = '0; in_sop = 0; in_eop = 0; in_vld = 0; in_hit = 0;
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic send_wr(input logic [1:0] fmt, input logic [1:0] cmd, input logic [3:0] bn,
                           input logic [8:0] qw, input logic [63:0] d, input bit hit, input bit gaps);
        logic [31:0] cw;
        cw = {13'b0, qw, 1'b0, bn, cmd, 3'b000};
        beat({1'b0, fmt, 5'b0, 8'h00, 16'h0002, 16'hBBBB, 8'h00, 8'h0F}, 1, 0, 1, hit);
        if (gaps) beat(64'hDEAD_BEEF_0000_0000, 1, 1, 0, 1);   // valid low: ignored (R9)
        beat({cw, d[63:32]}, 0, 0, 1, hit);
        if (gaps) beat(64'h4000_0000_0000_0000, 1, 0, 1, 0);   // region flag low: ignored (R9)
        beat({d[31:0], 32'h0}, 0, 1, 1, hit);
        quiet(0);
        in_vld = 0; in_sop = 0; in_eop = 0; in_hit = 0; in_data = '0;
    endtask

    initial begin : wd
        while (!done) begin
            @(posedge clk);
            if (cyc > 20000) begin
                errors++;
                $display("FAIL watchdog expired act=%0d exp=<20000", cyc);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin : main
        int base;
        logic [63:0] held;
        tick(); tick(); tick();
        rst = 0;
        @(negedge clk);
        chk("R1 reset outputs", {out_vld, out_sop, out_eop, out_half, out_data} == '0, out_data, 0);
        tick();

        // R6 latency and R7 stall
        out_rdy = 0;
        send_wr(2'b10, 2'b01, 4'd2, 9'd2, 64'h0000_0000_0000_0010, 1, 0);
        @(negedge clk); chk("R6 no output 1st sample", out_vld == 0, out_vld, 0);
        @(negedge clk); chk("R6 no output 2nd sample", out_vld == 0, out_vld, 0);
        @(negedge clk); chk("R6 header valid 3rd sample", out_vld && out_sop, out_vld, 1);
        held = out_data;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); chk("R7 held while stalled", out_vld && out_data == held, out_data, held);
        end
        out_rdy = 1;
        quiet(6);

        // R2/R3: SEND decoded, other codes dropped
        base = n_hs;
        send_wr(2'b10, 2'b00, 4'd1, 9'd4, 64'h100, 1, 0);
        send_wr(2'b10, 2'b10, 4'd1, 9'd4, 64'h100, 1, 0);
        send_wr(2'b10, 2'b11, 4'd1, 9'd4, 64'h100, 1, 0);
        quiet(8);
        chk("R3 non-SEND codes silent", n_hs == base, n_hs - base, 0);
        base = n_hs;
        send_wr(2'b10, 2'b01, 4'd15, 9'd511, 64'h1234_5678_9ABC_DEF7, 1, 0);
        quiet(8);
        chk("R2 SEND gives one request", n_hs == base + 1, n_hs - base, 1);

        // R9: ignored beats, other region, read header
        base = n_hs;
        send_wr(2'b10, 2'b01, 4'd3, 9'd3, 64'h0000_0000_CAFE_0008, 1, 1);
        quiet(8);
        chk("R9 gaps ignored, request made", n_hs == base + 1, n_hs - base, 1);
        base = n_hs;
        send_wr(2'b10, 2'b01, 4'd3, 9'd3, 64'h40, 0, 0);
        send_wr(2'b00, 2'b01, 4'd3, 9'd3, 64'h40, 1, 0);
        quiet(8);
        chk("R9 other region / read not decoded", n_hs == base, n_hs - base, 0);

        // R10: holding slot, then drop
        out_rdy = 0;
        base = n_hs;
        for (int k = 0; k < 4; k++)
            send_wr(2'b10, 2'b01, 4'(k + 4), 9'(k + 1), 64'(k * 64 + 8), 1, 0);
        quiet(4);
        out_rdy = 1;
        quiet(20);
        chk("R10 three served, fourth dropped", n_hs == base + 3, n_hs - base, 3);

        // back-to-back with ready toggling
        for (int k = 0; k < 3; k++) begin
            send_wr(2'b10, 2'b01, 4'(k), 9'(k + 7), 64'(k * 4096 + 3), 1, 0);
            out_rdy = (k % 2 == 0);
        end
        out_rdy = 1;
        quiet(20);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule